// File: doc/BRIEF.md
# Slotted Command Bus Serializer

This block converts a wide, slotted command/address word into the narrow per-pin command/address signals of a DRAM bus. Upstream logic runs at a system rate that is one quarter of the DRAM command rate. In each system period it presents one byte per DRAM pin. That byte holds four bit pairs, one pair for each of the four DRAM command slots in the period. The serializer captures this word, delays it by a fixed number of system periods, and then drives the pins one slot per DRAM clock. A command placed in slot s therefore lands at a known sub-period position on the bus.

The block uses a single clock: the DRAM-rate clock. An internal two-bit phase counter marks the four slots of each system period, and it is exported so that checkers can tell which slot is on the pins. Inputs are sampled only on the clock edge that ends slot 3. The two bits of a pair must carry the same value. If they differ, the even-indexed bit is driven and a sticky error flag is raised. Until the first captured word reaches the pins, the bus shows a deselected, powered-down idle state.

Top module: `slot_cmd_serializer`

## Requirements
- R1: After reset `slot_o` reads 0. It then advances by one on every clock, 0,1,2,3,0,..., and each value marks the slot currently on the output pins.
- R2: Inputs are sampled only on a rising edge at which `slot_o` is 3. Input values present at any other edge have no effect on the pins or on `pair_err_o`.
- R3: While `slot_o` equals k, each output pin carries bit 2k of its 8-bit input byte. Pin p of a bus uses input bits [8p+7:8p].
- R4: With LAT_SYS = L, a word sampled on capture edge n is on the pins during the four clocks that follow capture edge n+L-1, slot 0 first.
- R5: A bank-address byte pair of 16'h0C3C (BA0 in bits [7:0], BA1 in bits [15:8]) drives BA[1:0] to 0, 3, 1, 0 in slots 0 to 3.
- R6: A command in slot s of word N and one in slot t of word N+M appear 4M+t-s clocks apart on the pins. For example, ACT in slot 1 followed by a READ in slot 0 three words later gives 11 clocks.
- R7: During reset, and until the first captured word reaches the pins, CS_n, ACT_n and all ADR pins are high, and CKE, ODT, BA, BG and PAR are low. This gives a deselect on every slot.
- R8: If the two bits of a pair differ, the even-indexed bit is the one driven in that slot.
- R9: `pair_err_o` goes high on the clock after a capture edge that samples any mismatched pair. It stays high until reset, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| act_n_i | input | 8 | Activate strobe, four slots as bit pairs |
| adr_i | input | ADR_W*8 | Address pins, one byte per pin |
| ba_i | input | BA_W*8 | Bank address, one byte per pin |
| bg_i | input | BG_W*8 | Bank group, one byte per pin |
| cs_n_i | input | CS_W*8 | Chip selects, one byte per pin |
| cke_i | input | CKE_W*8 | Clock enables, one byte per pin |
| odt_i | input | ODT_W*8 | On-die termination, one byte per pin |
| par_i | input | 8 | Command parity, four slots |
| act_n_o | output | 1 | Activate strobe to DRAM |
| adr_o | output | ADR_W | Address pins to DRAM |
| ba_o | output | BA_W | Bank address to DRAM |
| bg_o | output | BG_W | Bank group to DRAM |
| cs_n_o | output | CS_W | Chip selects to DRAM |
| cke_o | output | CKE_W | Clock enables to DRAM |
| odt_o | output | ODT_W | Termination enables to DRAM |
| par_o | output | 1 | Parity to DRAM |
| slot_o | output | 2 | Slot currently on the pins |
| pair_err_o | output | 1 | Sticky mismatched-pair flag |

## Verification
The embedded properties check four things on every cycle: the slot counter steps in order, the output stage holds its word between capture edges, the error flag is set after a bad capture and never drops without reset, and the pins sit in the idle state right after reset. Other behaviours can only be shown by the bench's scenarios. These are the bit-to-slot mapping, the fixed latency, the 0x0C3C bank decode, the 11-clock ACT-to-READ spacing, the even-bit choice on a split pair, and the fact that junk driven between capture edges is ignored. The bench checks them against a word history that it keeps itself.

// File: rtl/cmdser_pkg.sv
package cmdser_pkg;

    localparam int SLOTS   = 4;
    localparam int BYTE_W  = 8;

    typedef logic [1:0] slot_t;

    // Value of one DRAM pin in a given slot: the even bit of the slot's pair.
    function automatic logic slot_bit(input logic [BYTE_W-1:0] pin_byte,
                                      input slot_t             slot);
        return pin_byte[{slot, 1'b0}];
    endfunction

    // True when any of the four pairs in a pin byte carries two different bits.
    function automatic logic pair_clash(input logic [BYTE_W-1:0] pin_byte);
        logic bad;
        bad = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            bad = bad | (pin_byte[2*k] ^ pin_byte[2*k+1]);
        end
        return bad;
    endfunction

endpackage

// File: rtl/cmdser_phase.sv
module cmdser_phase
    import cmdser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_t slot_o,
    output logic  cap_o
);

    slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + slot_t'(1);
        end
    end

    assign slot_o = slot_q;
    assign cap_o  = (slot_q == slot_t'(SLOTS - 1));

    // R1: the slot index steps by one, modulo four, on every clock out of reset
    p_slot_step_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (slot_q == slot_t'($past(slot_q) + slot_t'(1))));

endmodule

// File: rtl/cmdser_pipe.sv
module cmdser_pipe #(
    parameter int              W     = 8,
    parameter int              DEPTH = 2,
    parameter logic [W-1:0]    IDLE  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                stg[i] <= IDLE;
            end
        end else if (cap) begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[DEPTH-1];

    // R2: between capture edges the word on the output stage cannot change
    p_pipe_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(cap) && !$past(rst)) |-> $stable(q));

endmodule

// File: rtl/cmdser_slicer.sv
module cmdser_slicer
    import cmdser_pkg::*;
#(
    parameter int NPIN = 4
) (
    input  logic [NPIN*BYTE_W-1:0] word,
    input  slot_t                  slot,
    output logic [NPIN-1:0]        pins
);

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        assign pins[p] = slot_bit(word[p*BYTE_W +: BYTE_W], slot);
    end

endmodule

// File: rtl/cmdser_pair_check.sv
module cmdser_pair_check
    import cmdser_pkg::*;
#(
    parameter int NPIN = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cap,
    input  logic [NPIN*BYTE_W-1:0] word,
    output logic                   err_o
);

    logic [NPIN-1:0] clash;
    logic            err_q;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        assign clash[p] = pair_clash(word[p*BYTE_W +: BYTE_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (cap && (|clash)) begin
            err_q <= 1'b1;
        end
    end

    assign err_o = err_q;

    // R9: once raised, the flag holds until reset
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(err_q) && !$past(rst)) |-> err_q);

    // R9: sampling a split pair raises the flag on the next clock
    p_err_set_r9: assert property (@(posedge clk) disable iff (rst)
        (cap && (|clash)) |=> err_q);

endmodule

// File: rtl/slot_cmd_serializer.sv
module slot_cmd_serializer
    import cmdser_pkg::*;
#(
    parameter int ADR_W   = 17,
    parameter int BA_W    = 2,
    parameter int BG_W    = 2,
    parameter int CS_W    = 2,
    parameter int CKE_W   = 1,
    parameter int ODT_W   = 1,
    parameter int LAT_SYS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [7:0]            act_n_i,
    input  logic [ADR_W*8-1:0]    adr_i,
    input  logic [BA_W*8-1:0]     ba_i,
    input  logic [BG_W*8-1:0]     bg_i,
    input  logic [CS_W*8-1:0]     cs_n_i,
    input  logic [CKE_W*8-1:0]    cke_i,
    input  logic [ODT_W*8-1:0]    odt_i,
    input  logic [7:0]            par_i,
    output logic                  act_n_o,
    output logic [ADR_W-1:0]      adr_o,
    output logic [BA_W-1:0]       ba_o,
    output logic [BG_W-1:0]       bg_o,
    output logic [CS_W-1:0]       cs_n_o,
    output logic [CKE_W-1:0]      cke_o,
    output logic [ODT_W-1:0]      odt_o,
    output logic                  par_o,
    output logic [1:0]            slot_o,
    output logic                  pair_err_o
);

    // Pin numbering inside the flattened word, lowest first.
    localparam int OFF_ADR = 1;
    localparam int OFF_BA  = OFF_ADR + ADR_W;
    localparam int OFF_BG  = OFF_BA  + BA_W;
    localparam int OFF_CS  = OFF_BG  + BG_W;
    localparam int OFF_CKE = OFF_CS  + CS_W;
    localparam int OFF_ODT = OFF_CKE + CKE_W;
    localparam int OFF_PAR = OFF_ODT + ODT_W;
    localparam int NPIN    = OFF_PAR + 1;
    localparam int WW      = NPIN * BYTE_W;

    // Idle word: active-low strobes and address high, everything else low.
    function automatic logic [WW-1:0] idle_word();
        logic [WW-1:0] v;
        v = '0;
        for (int p = 0; p < NPIN; p++) begin
            if (p < OFF_BA || (p >= OFF_CS && p < OFF_CKE)) begin
                v[p*BYTE_W +: BYTE_W] = '1;
            end
        end
        return v;
    endfunction

    localparam logic [WW-1:0] IDLE_W = idle_word();

    logic [WW-1:0]   word_in;
    logic [WW-1:0]   word_out;
    logic [NPIN-1:0] pins;
    slot_t           slot;
    logic            cap;

    assign word_in = {par_i, odt_i, cke_i, cs_n_i, bg_i, ba_i, adr_i, act_n_i};

    cmdser_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .slot_o (slot),
        .cap_o  (cap)
    );

    cmdser_pipe #(
        .W     (WW),
        .DEPTH (LAT_SYS),
        .IDLE  (IDLE_W)
    ) u_pipe (
        .clk (clk),
        .rst (rst),
        .cap (cap),
        .d   (word_in),
        .q   (word_out)
    );

    cmdser_slicer #(
        .NPIN (NPIN)
    ) u_slicer (
        .word (word_out),
        .slot (slot),
        .pins (pins)
    );

    cmdser_pair_check #(
        .NPIN (NPIN)
    ) u_check (
        .clk   (clk),
        .rst   (rst),
        .cap   (cap),
        .word  (word_in),
        .err_o (pair_err_o)
    );

    assign act_n_o = pins[0];
    assign adr_o   = pins[OFF_ADR +: ADR_W];
    assign ba_o    = pins[OFF_BA  +: BA_W];
    assign bg_o    = pins[OFF_BG  +: BG_W];
    assign cs_n_o  = pins[OFF_CS  +: CS_W];
    assign cke_o   = pins[OFF_CKE +: CKE_W];
    assign odt_o   = pins[OFF_ODT +: ODT_W];
    assign par_o   = pins[OFF_PAR];
    assign slot_o  = slot;

    // R7: the clock after reset shows a deselected, powered-down bus
    p_reset_idle_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((&cs_n_o) && act_n_o && (cke_o == '0) && (odt_o == '0)));

endmodule

// File: tb/slot_cmd_serializer_tb.sv
module slot_cmd_serializer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADR_W = 17, BA_W = 2, BG_W = 2, CS_W = 2;
    localparam int CKE_W = 1, ODT_W = 1, LAT = 2;
    localparam int OFF_ADR = 1;
    localparam int OFF_BA  = OFF_ADR + ADR_W;
    localparam int OFF_BG  = OFF_BA + BA_W;
    localparam int OFF_CS  = OFF_BG + BG_W;
    localparam int OFF_CKE = OFF_CS + CS_W;
    localparam int OFF_ODT = OFF_CKE + CKE_W;
    localparam int OFF_PAR = OFF_ODT + ODT_W;
    localparam int NPIN    = OFF_PAR + 1;
    localparam int VW      = NPIN * 8;
    localparam int NW      = 300;
    localparam int IDX_BA  = 5;
    localparam int IDX_ACT = 10;
    localparam int IDX_RD  = 13;
    localparam int IDX_BAD = NW - 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [VW-1:0] drv;
    int n_chk = 0;
    int n_fail = 0;

    logic act_n_o, par_o, pair_err_o;
    logic [ADR_W-1:0] adr_o;
    logic [BA_W-1:0] ba_o;
    logic [BG_W-1:0] bg_o;
    logic [CS_W-1:0] cs_n_o;
    logic [CKE_W-1:0] cke_o;
    logic [ODT_W-1:0] odt_o;
    logic [1:0] slot_o;
    logic [NPIN-1:0] pins_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_cmd_serializer u_dut (
        .clk (clk), .rst (rst),
        .act_n_i (drv[7:0]),
        .adr_i   (drv[OFF_ADR*8 +: ADR_W*8]),
        .ba_i    (drv[OFF_BA*8  +: BA_W*8]),
        .bg_i    (drv[OFF_BG*8  +: BG_W*8]),
        .cs_n_i  (drv[OFF_CS*8  +: CS_W*8]),
        .cke_i   (drv[OFF_CKE*8 +: CKE_W*8]),
        .odt_i   (drv[OFF_ODT*8 +: ODT_W*8]),
        .par_i   (drv[OFF_PAR*8 +: 8]),
        .act_n_o (act_n_o), .adr_o (adr_o), .ba_o (ba_o), .bg_o (bg_o),
        .cs_n_o  (cs_n_o), .cke_o (cke_o), .odt_o (odt_o), .par_o (par_o),
        .slot_o  (slot_o), .pair_err_o (pair_err_o)
    );

    assign pins_o = {par_o, odt_o, cke_o, cs_n_o, bg_o, ba_o, adr_o, act_n_o};

    logic [VW-1:0] hist [NW + LAT + 2];

    function automatic logic [VW-1:0] idle_vec();
        logic [VW-1:0] v = '0;
        for (int p = 0; p < NPIN; p++)
            if (p < OFF_BA || (p >= OFF_CS && p < OFF_CKE)) v[p*8 +: 8] = 8'hFF;
        return v;
    endfunction

    function automatic logic [VW-1:0] rand_matched();
        logic [VW-1:0] v;
        for (int p = 0; p < NPIN; p++)
            for (int k = 0; k < 4; k++) begin
                logic b = 1'($urandom % 2);
                v[p*8 + 2*k] = b;
                v[p*8 + 2*k + 1] = b;
            end
        return v;
    endfunction

    function automatic logic [VW-1:0] rand_raw();
        logic [VW-1:0] v;
        for (int i = 0; i < VW; i++) v[i] = 1'($urandom % 2);
        return v;
    endfunction

    // Expected pins for slot s: bit 2s of every pin byte
    function automatic logic [NPIN-1:0] exp_pins(input logic [VW-1:0] v, input int s);
        logic [NPIN-1:0] r;
        for (int p = 0; p < NPIN; p++) r[p] = v[p*8 + 2*s];
        return r;
    endfunction

    function automatic logic has_clash(input logic [VW-1:0] v);
        logic c = 1'b0;
        for (int i = 0; i < VW; i += 2) c = c | (v[i] ^ v[i+1]);
        return c;
    endfunction

    // Clear pair s of pin p (drive it low in that slot)
    function automatic logic [VW-1:0] pull_low(input logic [VW-1:0] v, input int p, input int s);
        logic [VW-1:0] r = v;
        r[p*8 + 2*s] = 1'b0;
        r[p*8 + 2*s + 1] = 1'b0;
        return r;
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin : main
        int cc, ncyc, exp_slot, t_act, t_rd;
        logic exp_err;
        logic [VW-1:0] ew;
        logic [1:0] ba_exp [4];
        ba_exp[0] = 2'd0; ba_exp[1] = 2'd3; ba_exp[2] = 2'd1; ba_exp[3] = 2'd0;
        void'($urandom(32'h5EED_1234));

        for (int i = 0; i < NW + LAT + 2; i++) hist[i] = idle_vec();
        for (int i = 20; i < NW; i++) hist[i] = rand_matched();
        hist[IDX_BA] = idle_vec();
        hist[IDX_BA][OFF_BA*8 +: 16] = 16'h0C3C;
        hist[IDX_ACT] = pull_low(pull_low(idle_vec(), 0, 1), OFF_CS, 1);
        hist[IDX_RD]  = pull_low(pull_low(idle_vec(), OFF_ADR + 15, 0), OFF_CS, 0);
        hist[IDX_BAD][OFF_ODT*8 +: 8] = 8'h01;

        drv = rand_raw();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R7 reset state, R1 first slot, R9 cleared flag
        check(pins_o == exp_pins(idle_vec(), 0), "R7 idle pins", 256'(pins_o),
              256'(exp_pins(idle_vec(), 0)));
        check(slot_o == 2'd0, "R1 slot after reset", 256'(slot_o), 256'd0);
        check(pair_err_o == 1'b0, "R9 flag after reset", 256'(pair_err_o), 256'd0);

        cc = 0; ncyc = 0; exp_slot = 0; exp_err = 1'b0; t_act = -1; t_rd = -1;
        while (cc < NW + LAT + 1) begin
            ew = (cc >= LAT) ? hist[cc - LAT] : idle_vec();
            check(slot_o == 2'(exp_slot), "R1 slot sequence", 256'(slot_o), 256'(exp_slot));
            check(pins_o == exp_pins(ew, exp_slot), "R2 R3 R4 R8 pins per slot",
                  256'(pins_o), 256'(exp_pins(ew, exp_slot)));
            check(pair_err_o == exp_err, "R9 flag", 256'(pair_err_o), 256'(exp_err));
            if (cc - LAT == IDX_BA)
                check(ba_o == ba_exp[exp_slot], "R5 bank decode", 256'(ba_o),
                      256'(ba_exp[exp_slot]));
            if (cc - LAT == IDX_BAD && exp_slot == 0)
                check(odt_o[0] == 1'b1, "R8 even bit of split pair", 256'(odt_o), 256'd1);
            if (cc - LAT == IDX_ACT && act_n_o == 1'b0) t_act = ncyc;
            if (cc - LAT == IDX_RD && cs_n_o[0] == 1'b0 && act_n_o) t_rd = ncyc;

            if (exp_slot == 3) drv = hist[cc];
            else drv = rand_raw();   // junk between capture edges (R2)
            @(posedge clk);
            ncyc++;
            if (exp_slot == 3) begin
                exp_err = exp_err | has_clash(hist[cc]);
                cc++;
            end
            exp_slot = (exp_slot + 1) % 4;
            @(negedge clk);
        end

        check(t_act >= 0 && t_rd - t_act == 11, "R6 ACT to READ spacing",
              256'(t_rd - t_act), 256'd11);
        check(exp_err == 1'b1, "R9 split pair seen", 256'(exp_err), 256'd1);

        rst = 1'b1;
        @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check(pair_err_o == 1'b0, "R9 flag cleared by reset", 256'(pair_err_o), 256'd0);
        check(pins_o == exp_pins(idle_vec(), 0), "R7 idle after second reset",
              256'(pins_o), 256'(exp_pins(idle_vec(), 0)));
        check(slot_o == 2'd0, "R1 slot restarts", 256'(slot_o), 256'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule